// File: doc/BRIEF.md
# Comparator Control and Status Register

This block is the clock-domain side of one analog comparator. It holds an 8-bit control and status register on a byte-wide register bus. The register is decoded at an address set by a parameter. Software uses it to turn the comparator on, to pick its positive and negative inputs, and to route the raw comparator result to an output pin. It also reads back a synchronized copy of the result and an interrupt flag.

The raw result is asynchronous, so it passes through a flop synchronizer before software or the interrupt logic sees it. Every change of the synchronized value, rising or falling, sets a sticky flag. Software clears the flag by writing 0 to it. Turning the comparator off clears the synchronized value and the flag. To cover two comparators, place two instances at adjacent addresses (0xAC and 0xAD by default).

Top module: `cmp_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00, and cmp_en, pos_sel, neg_sel, pin_oe, pin_out and irq are all 0.
- R2: A write to any address other than REG_ADDR leaves the register unchanged. A read at any other address returns 0x00.
- R3: The writable fields are bit 5 (enable), bit 4 (positive input select: 0 = input A, 1 = input B), bit 3 (negative input select: 0 = external reference, 1 = internal reference) and bit 2 (pin output enable). They read back as written and drive cmp_en, pos_sel and neg_sel.
- R4: Bits 7 and 6 always read 0. Writes to bit 1 are ignored.
- R5: pin_oe is 1 only when enable and output enable are both 1. pin_out equals cmp_raw combinationally when pin_oe is 1, and is 0 otherwise.
- R6: While enabled, bit 1 shows cmp_raw after two rising clock edges. While disabled, bit 1 reads 0.
- R7: The flag (bit 0) is set at the clock edge after bit 1 changes, for either direction of change. It is not set while bit 1 is steady.
- R8: Writing 0 to bit 0 clears the flag at that write. Writing 1 to bit 0 does not change the flag.
- R9: The clock edge that clears enable also clears bit 1 and the flag.
- R10: If a flag set by hardware and a software clear fall on the same edge, the flag ends up set.
- R11: irq equals the flag ANDed with irq_en.
- R12: Enabling while cmp_raw is 1 shows bit 1 one edge after the enabling write. The flag follows one edge later. Enabling while cmp_raw is 0 sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when not addressed) |
| cmp_raw | input | 1 | Asynchronous comparator result |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| cmp_en | output | 1 | Comparator enable to the analog block |
| pos_sel | output | 1 | Positive input select |
| neg_sel | output | 1 | Negative input select |
| pin_oe | output | 1 | Pin mux output enable |
| pin_out | output | 1 | Ungated-by-clock comparator result to the pin |
| irq | output | 1 | Interrupt request |

## Verification
Each state fault in this block reaches the ports within a few cycles:
- A stuck synchronizer stage shows as bit 1 missing its two-edge latency. This appears on the first read after cmp_raw changes.
- A wrong change detector shows in one of two ways. Either the flag does not appear on the third edge after a raw transition, or the flag appears with no transition.
- Wrong clear ordering shows as a flag that a software clear on the same edge leaves at 0. It can also show as status bits that stay set after the disabling write.
- Decode and field mistakes show as read-back values or select outputs that differ from what was written.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
    localparam int EN_BIT   = 5;
    localparam int PSEL_BIT = 4;
    localparam int NSEL_BIT = 3;
    localparam int OE_BIT   = 2;
    localparam int CO_BIT   = 1;
    localparam int FLAG_BIT = 0;

    typedef struct packed {
        logic en;
        logic psel;
        logic nsel;
        logic oe;
    } ctrl_t;

    typedef struct packed {
        logic prev;
        logic flag;
    } det_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        if (clr) begin
            chain_d = '0;
        end else begin
            chain_d = {chain_q[STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_change_flag.sv
module cmp_change_flag
    import cmp_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic level,
    input  logic sw_clr,
    output logic flag
);
    det_t det_d, det_q;
    logic change;

    always_comb begin
        change = level ^ det_q.prev;
        det_d  = det_q;
        if (clr) begin
            det_d = '0;
        end else begin
            det_d.prev = level;
            det_d.flag = change | (det_q.flag & ~sw_clr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign flag = det_q.flag;
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
    import cmp_ctrl_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 'hAC,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cmp_raw,
    input  logic              irq_en,
    output logic              cmp_en,
    output logic              pos_sel,
    output logic              neg_sel,
    output logic              pin_oe,
    output logic              pin_out,
    output logic              irq
);
    ctrl_t ctrl_d, ctrl_q;
    logic  hit, wr_hit, sw_clr, clr_all;
    logic  co_s, flag_s, oe_q;
    logic  unused_wbits;

    assign unused_wbits = ^{bus_wdata[7:6], bus_wdata[CO_BIT]};

    always_comb begin
        hit    = (bus_addr == REG_ADDR);
        wr_hit = hit & bus_wr;
        ctrl_d = ctrl_q;
        if (wr_hit) begin
            ctrl_d.en   = bus_wdata[EN_BIT];
            ctrl_d.psel = bus_wdata[PSEL_BIT];
            ctrl_d.nsel = bus_wdata[NSEL_BIT];
            ctrl_d.oe   = bus_wdata[OE_BIT];
        end
        sw_clr  = wr_hit & ~bus_wdata[FLAG_BIT];
        clr_all = ~ctrl_d.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .din   (cmp_raw),
        .dout  (co_s)
    );

    cmp_change_flag u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_all),
        .level  (co_s),
        .sw_clr (sw_clr),
        .flag   (flag_s)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[EN_BIT]   = ctrl_q.en;
            bus_rdata[PSEL_BIT] = ctrl_q.psel;
            bus_rdata[NSEL_BIT] = ctrl_q.nsel;
            bus_rdata[OE_BIT]   = ctrl_q.oe;
            bus_rdata[CO_BIT]   = co_s;
            bus_rdata[FLAG_BIT] = flag_s;
        end
    end

    assign oe_q    = ctrl_q.oe;
    assign cmp_en  = ctrl_q.en;
    assign pos_sel = ctrl_q.psel;
    assign neg_sel = ctrl_q.nsel;
    assign pin_oe  = ctrl_q.en & ctrl_q.oe;
    assign pin_out = cmp_raw & pin_oe;
    assign irq     = flag_s & irq_en;
endmodule

// File: rtl/cmp_ctrl_reg_chk.sv
module cmp_ctrl_reg_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic oe,
    input logic co,
    input logic flag,
    input logic irq_en,
    input logic irq,
    input logic pin_out
);
    p_pin_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && oe) |-> !pin_out);

    p_off_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!co && !flag));

    p_flag_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (co != $past(co))) |=> (flag || !en));

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (co == $past(co)) && !flag) |=> !flag);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && en));
endmodule

bind cmp_ctrl_reg cmp_ctrl_reg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cmp_en),
    .oe      (oe_q),
    .co      (co_s),
    .flag    (flag_s),
    .irq_en  (irq_en),
    .irq     (irq),
    .pin_out (pin_out)
);

// File: tb/cmp_ctrl_reg_tb.sv
module cmp_ctrl_reg_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] bus_addr = 8'hAC;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       cmp_raw = 0;
    logic       irq_en = 0;
    logic       cmp_en, pos_sel, neg_sel, pin_oe, pin_out, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_req = 0;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    cmp_ctrl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
        .irq_en(irq_en), .cmp_en(cmp_en), .pos_sel(pos_sel), .neg_sel(neg_sel),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
    );

    // monitor: pops expected read items and compares against bus_rdata
    initial begin
        forever begin
            @(negedge clk);
            if (mon_req) begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: rdata got %02h expected %02h", it.tag, bus_rdata, it.exp);
                end
                mon_req = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        tick(1);
        bus_wr = 0; bus_addr = 8'hAC;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        mon_req = 1;
        @(negedge clk); #1;
        bus_addr = 8'hAC;
    endtask

    task automatic chk(input logic got, input logic e, input string tag);
        n_cmp++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, e);
        end
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        rd_exp(8'hAC, 8'h00, "R1 reset value");
        chk(cmp_en | pos_sel | neg_sel | pin_oe | pin_out | irq, 1'b0, "R1 outputs low");
        // R2 decode
        wr_reg(8'hAD, 8'h3C);
        rd_exp(8'hAC, 8'h00, "R2 foreign write ignored");
        rd_exp(8'hAD, 8'h00, "R2 foreign read zero");
        // R3 R4 fields, reserved and bit1 ignored
        cmp_raw = 1;
        wr_reg(8'hAC, 8'hDE);
        rd_exp(8'hAC, 8'h1C, "R4 reserved/bit1 dropped, R3 fields");
        chk(pos_sel, 1'b1, "R3 pos_sel");
        chk(neg_sel, 1'b1, "R3 neg_sel");
        chk(pin_out, 1'b0, "R5 pin gated while disabled");
        chk(pin_oe, 1'b0, "R5 pin_oe needs enable");
        wr_reg(8'hAC, 8'h18);
        rd_exp(8'hAC, 8'h18, "R3 readback");
        // R12 enable with raw low: no flag
        cmp_raw = 0;
        wr_reg(8'hAC, 8'h24);
        tick(2);
        rd_exp(8'hAC, 8'h24, "R12 no flag when raw low");
        chk(cmp_en, 1'b1, "R3 cmp_en");
        chk(pin_oe, 1'b1, "R5 pin_oe");
        // R5 async pin path, R6 latency, R7 rising change
        cmp_raw = 1;
        #1 chk(pin_out, 1'b1, "R5 pin follows raw");
        tick(1);
        rd_exp(8'hAC, 8'h24, "R6 not yet after one edge");
        tick(1);
        rd_exp(8'hAC, 8'h26, "R6 synced after two edges");
        tick(1);
        rd_exp(8'hAC, 8'h27, "R7 flag on rise");
        chk(irq, 1'b0, "R11 irq masked");
        irq_en = 1;
        #1 chk(irq, 1'b1, "R11 irq asserted");
        // R8 clear rules
        wr_reg(8'hAC, 8'h25);
        rd_exp(8'hAC, 8'h27, "R8 write 1 keeps flag");
        wr_reg(8'hAC, 8'h24);
        rd_exp(8'hAC, 8'h26, "R8 write 0 clears flag");
        chk(irq, 1'b0, "R11 irq drops with flag");
        // R7 falling change
        cmp_raw = 0;
        tick(2);
        rd_exp(8'hAC, 8'h24, "R6 falls after two edges");
        tick(1);
        rd_exp(8'hAC, 8'h25, "R7 flag on fall");
        wr_reg(8'hAC, 8'h24);
        rd_exp(8'hAC, 8'h24, "R8 cleared again");
        // R10 set beats clear
        cmp_raw = 1;
        tick(2);
        wr_reg(8'hAC, 8'h24);
        rd_exp(8'hAC, 8'h27, "R10 hardware set wins");
        // R9 disable clears status
        wr_reg(8'hAC, 8'h04);
        rd_exp(8'hAC, 8'h04, "R9 status cleared on disable");
        chk(pin_out, 1'b0, "R5 pin off when disabled");
        chk(irq, 1'b0, "R9 irq gone");
        tick(3);
        rd_exp(8'hAC, 8'h04, "R6 bit1 zero while disabled");
        // R12 enable with raw high
        wr_reg(8'hAC, 8'h20);
        tick(1);
        rd_exp(8'hAC, 8'h22, "R12 bit1 one edge after enable");
        tick(1);
        rd_exp(8'hAC, 8'h23, "R12 flag follows");
        tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule